// File: doc/BRIEF.md
# Segment Translation Unit

The block sits between a processor's logical address bus and physical memory. It holds a table of segment descriptors. Each descriptor has its own power-of-two size, a logical base, a physical base, a valid bit and a write-enable bit. Every bus access is compared against all valid descriptors at once. The compare is masked, so only the address bits above each segment's own size boundary take part. A hit that the segment's permission allows produces a relocated physical address and a one-cycle strobe for the external address latches. An access that misses, or a write to a segment that is not writable, raises a one-cycle fault that aborts the bus cycle instead.

Software loads and reads the descriptors through a chip-selected register port. Each register transfer completes after a fixed, parameterised number of wait cycles, from 8 to 20. When it completes, the block acknowledges it. For a read, the register contents appear on the same output pins that otherwise carry the physical address.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every descriptor is invalid (control field reads 0), `pa_stb_o`, `fault_o` and `reg_ack_o` are low, `pbus_o` is 0, and every bus access faults until a descriptor is programmed.
- R2: A size code n (4 bits, control bits 7:4) selects a segment of 2^(n+8) bytes. A valid entry matches when logical address bits 23 down to n+8 equal the same bits of its logical base. Base bits below the size boundary are ignored.
- R3: On a hit, the physical address is taken from two sources. Bits at and above n+8 come from the entry's physical base. Bits below n+8 come unchanged from the logical address. Physical base bits below the boundary are ignored.
- R4: A write access (`wr_i`=1) to a matching entry whose write-enable bit (control bit 1) is 0 faults. Reads of that entry and writes to a writable entry succeed.
- R5: An access that matches no valid entry faults.
- R6: When several valid entries match, the lowest-numbered one decides both the permission and the relocation.
- R7: An access sampled with `as_i` high gives exactly one of `pa_stb_o` or `fault_o` for one cycle, one clock later, with the physical address on `pbus_o` during the strobe.
- R8: A register transfer captured with `cs_i` high is acknowledged by a one-cycle `reg_ack_o` exactly REG_WAIT clocks after capture. The field select is 0 for the logical base (address bits 23:8), 1 for the physical base (bits 23:8) and 2 for the control word (bit 0 valid, bit 1 write-enable, bits 7:4 size). A read returns its data on `pbus_o[15:0]` during the acknowledge.
- R9: While a register transfer is pending, `as_i` produces neither strobe nor fault, and a further `cs_i` is ignored and leaves the table unchanged.
- R10: Reading a field returns the last value written, with unused control bits as 0. Field select 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_i | input | 1 | Bus access request, sampled each clock |
| wr_i | input | 1 | Access type, 1 = write |
| la_i | input | LA_W | Logical address |
| cs_i | input | 1 | Register transfer select |
| reg_wr_i | input | 1 | Register transfer direction, 1 = write |
| reg_idx_i | input | IDX_W | Descriptor number |
| reg_fld_i | input | 2 | Descriptor field select |
| reg_wdata_i | input | DW | Register write data |
| pbus_o | output | PA_W | Physical address, or register read data during acknowledge |
| pa_stb_o | output | 1 | Physical address valid strobe |
| fault_o | output | 1 | Access fault, aborts the bus cycle |
| reg_ack_o | output | 1 | Register transfer complete |

## Verification
The bench builds the block with 32 descriptors, 24-bit logical and physical addresses, a 16-bit register port and a wait count of 11 rather than the default 8. The non-default wait count checks that the acknowledge latency follows the parameter and is not fixed at its lower limit. With these widths the two extreme size codes can be reached: 0 gives 256-byte segments and 15 gives half the address space, where only the top address bit is compared. Random descriptor sets with overlapping segments exercise the lowest-entry priority. A bus access and a second register request are issued while a transfer is still waiting, to check that both are refused.

// File: rtl/seg_xlate_pkg.sv
`timescale 1ns/1ps
package seg_xlate_pkg;

   // Descriptor field selector used by the register port.
   typedef enum logic [1:0] {
      FLD_LBASE = 2'd0,
      FLD_PBASE = 2'd1,
      FLD_CTRL  = 2'd2,
      FLD_NONE  = 2'd3
   } seg_fld_e;

   // Control word layout.
   localparam int unsigned CTRL_VLD_BIT = 0;
   localparam int unsigned CTRL_WEN_BIT = 1;
   localparam int unsigned CTRL_SZ_LSB  = 4;

endpackage

// File: rtl/seg_reg_port.sv
`timescale 1ns/1ps
module seg_reg_port #(
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned DW       = 16,
   parameter int unsigned REG_WAIT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_i,
   input  logic             rw_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [1:0]       fld_i,
   input  logic [DW-1:0]    wdata_i,
   input  logic [DW-1:0]    tbl_rdata_i,
   output logic             busy_o,
   output logic             commit_o,
   output logic [IDX_W-1:0] cmd_idx_o,
   output logic [1:0]       cmd_fld_o,
   output logic [DW-1:0]    cmd_wdata_o,
   output logic             ack_o,
   output logic [DW-1:0]    rdata_o
);

   localparam int unsigned      CNT_W    = $clog2(REG_WAIT + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REG_WAIT - 1);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rw_q;
   logic [IDX_W-1:0] idx_q;
   logic [1:0]       fld_q;
   logic [DW-1:0]    wdata_q;
   logic             ack_q;
   logic [DW-1:0]    rdata_q;
   logic             last_w;

   assign last_w = busy_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         rw_q    <= 1'b0;
         idx_q   <= '0;
         fld_q   <= '0;
         wdata_q <= '0;
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q <= 1'b0;
         if (busy_q) begin
            if (last_w) begin
               busy_q  <= 1'b0;
               ack_q   <= 1'b1;
               rdata_q <= rw_q ? '0 : tbl_rdata_i;
            end else begin
               cnt_q <= cnt_q - CNT_ONE;
            end
         end else if (cs_i) begin
            busy_q  <= 1'b1;
            cnt_q   <= CNT_LOAD;
            rw_q    <= rw_i;
            idx_q   <= idx_i;
            fld_q   <= fld_i;
            wdata_q <= wdata_i;
         end
      end
   end

   assign busy_o      = busy_q;
   assign commit_o    = last_w && rw_q;
   assign cmd_idx_o   = idx_q;
   assign cmd_fld_o   = fld_q;
   assign cmd_wdata_o = wdata_q;
   assign ack_o       = ack_q;
   assign rdata_o     = rdata_q;

endmodule

// File: rtl/seg_desc_table.sv
`timescale 1ns/1ps
module seg_desc_table
   import seg_xlate_pkg::*;
#(
   parameter int unsigned N     = 32,
   parameter int unsigned IDX_W = 5,
   parameter int unsigned HB    = 16,
   parameter int unsigned PB    = 16,
   parameter int unsigned SZ_W  = 4,
   parameter int unsigned DW    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_i,
   input  logic [IDX_W-1:0]         idx_i,
   input  logic [1:0]               fld_i,
   input  logic [DW-1:0]            wdata_i,
   output logic [DW-1:0]            rdata_o,
   output logic [N-1:0]             vld_o,
   output logic [N-1:0]             wen_o,
   output logic [N-1:0][SZ_W-1:0]   sz_o,
   output logic [N-1:0][HB-1:0]     lbase_o,
   output logic [N-1:0][PB-1:0]     pbase_o
);

   localparam bit FULL_MAP = (N == (1 << IDX_W));

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic            hit_w;
      logic            vld_q;
      logic            wen_q;
      logic [SZ_W-1:0] sz_q;
      logic [HB-1:0]   lb_q;
      logic [PB-1:0]   pb_q;

      assign hit_w = we_i && (idx_i == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            wen_q <= 1'b0;
            sz_q  <= '0;
            lb_q  <= '0;
            pb_q  <= '0;
         end else if (hit_w) begin
            case (seg_fld_e'(fld_i))
               FLD_LBASE: lb_q <= wdata_i[HB-1:0];
               FLD_PBASE: pb_q <= wdata_i[PB-1:0];
               FLD_CTRL: begin
                  vld_q <= wdata_i[CTRL_VLD_BIT];
                  wen_q <= wdata_i[CTRL_WEN_BIT];
                  sz_q  <= wdata_i[CTRL_SZ_LSB +: SZ_W];
               end
               default: ;
            endcase
         end
      end

      assign vld_o[i]   = vld_q;
      assign wen_o[i]   = wen_q;
      assign sz_o[i]    = sz_q;
      assign lbase_o[i] = lb_q;
      assign pbase_o[i] = pb_q;
   end

   // Index range guard only exists when the index field can exceed the table.
   logic idx_ok_w;
   if (FULL_MAP) begin : g_full
      assign idx_ok_w = 1'b1;
   end else begin : g_part
      assign idx_ok_w = (idx_i < IDX_W'(N));
   end

   always_comb begin
      rdata_o = '0;
      if (idx_ok_w) begin
         case (seg_fld_e'(fld_i))
            FLD_LBASE: rdata_o[HB-1:0] = lbase_o[idx_i];
            FLD_PBASE: rdata_o[PB-1:0] = pbase_o[idx_i];
            FLD_CTRL: begin
               rdata_o[CTRL_VLD_BIT]            = vld_o[idx_i];
               rdata_o[CTRL_WEN_BIT]            = wen_o[idx_i];
               rdata_o[CTRL_SZ_LSB +: SZ_W]     = sz_o[idx_i];
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/seg_cam_match.sv
`timescale 1ns/1ps
module seg_cam_match #(
   parameter int unsigned N     = 32,
   parameter int unsigned HB    = 16,
   parameter int unsigned SZ_W  = 4,
   parameter int unsigned IDX_W = 5
) (
   input  logic [HB-1:0]            la_hi_i,
   input  logic [N-1:0]             vld_i,
   input  logic [N-1:0][SZ_W-1:0]   sz_i,
   input  logic [N-1:0][HB-1:0]     lbase_i,
   output logic                     hit_o,
   output logic [IDX_W-1:0]         sel_o,
   output logic [HB-1:0]            mask_o
);

   logic [N-1:0]         match_w;
   logic [N-1:0][HB-1:0] mask_w;

   // One masked comparator per descriptor, all evaluated in parallel.
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign mask_w[i]  = {HB{1'b1}} << sz_i[i];
      assign match_w[i] = vld_i[i] && (((la_hi_i ^ lbase_i[i]) & mask_w[i]) == '0);
   end

   // Lowest index wins: scan from the top so the smallest match is kept last.
   always_comb begin
      hit_o  = |match_w;
      sel_o  = '0;
      mask_o = '1;
      for (int i = N - 1; i >= 0; i--) begin
         if (match_w[i]) begin
            sel_o  = IDX_W'(i);
            mask_o = mask_w[i];
         end
      end
   end

endmodule

// File: rtl/seg_xlate_unit.sv
`timescale 1ns/1ps
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int unsigned N_SEG     = 32,
   parameter int unsigned LA_W      = 24,
   parameter int unsigned PA_W      = 24,
   parameter int unsigned MIN_SHIFT = 8,
   parameter int unsigned SZ_W      = 4,
   parameter int unsigned DW        = 16,
   parameter int unsigned REG_WAIT  = 8,
   localparam int unsigned IDX_W    = $clog2(N_SEG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             as_i,
   input  logic             wr_i,
   input  logic [LA_W-1:0]  la_i,
   input  logic             cs_i,
   input  logic             reg_wr_i,
   input  logic [IDX_W-1:0] reg_idx_i,
   input  logic [1:0]       reg_fld_i,
   input  logic [DW-1:0]    reg_wdata_i,
   output logic [PA_W-1:0]  pbus_o,
   output logic             pa_stb_o,
   output logic             fault_o,
   output logic             reg_ack_o
);

   localparam int unsigned HB = LA_W - MIN_SHIFT;
   localparam int unsigned PB = PA_W - MIN_SHIFT;

   // Elaboration-time parameter checks.
   if (N_SEG < 2) begin : g_bad_n
      $error("seg_xlate_unit: N_SEG must be at least 2");
   end
   if (REG_WAIT < 8 || REG_WAIT > 20) begin : g_bad_wait
      $error("seg_xlate_unit: REG_WAIT must lie in 8..20");
   end
   if (LA_W <= MIN_SHIFT || HB < (1 << SZ_W) - 1) begin : g_bad_la
      $error("seg_xlate_unit: LA_W too narrow for the size codes");
   end
   if (PA_W < LA_W) begin : g_bad_pa
      $error("seg_xlate_unit: PA_W must not be below LA_W");
   end
   if (DW < PB || DW < CTRL_SZ_LSB + SZ_W || PA_W < DW) begin : g_bad_dw
      $error("seg_xlate_unit: DW does not fit the descriptor fields or output bus");
   end

   // Register port
   logic             busy_w;
   logic             commit_w;
   logic [IDX_W-1:0] cmd_idx_w;
   logic [1:0]       cmd_fld_w;
   logic [DW-1:0]    cmd_wdata_w;
   logic             ack_w;
   logic [DW-1:0]    port_rdata_w;
   logic [DW-1:0]    tbl_rdata_w;

   seg_reg_port #(
      .IDX_W    (IDX_W),
      .DW       (DW),
      .REG_WAIT (REG_WAIT)
   ) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_i        (cs_i),
      .rw_i        (reg_wr_i),
      .idx_i       (reg_idx_i),
      .fld_i       (reg_fld_i),
      .wdata_i     (reg_wdata_i),
      .tbl_rdata_i (tbl_rdata_w),
      .busy_o      (busy_w),
      .commit_o    (commit_w),
      .cmd_idx_o   (cmd_idx_w),
      .cmd_fld_o   (cmd_fld_w),
      .cmd_wdata_o (cmd_wdata_w),
      .ack_o       (ack_w),
      .rdata_o     (port_rdata_w)
   );

   // Descriptor storage
   logic [N_SEG-1:0]           vld_w;
   logic [N_SEG-1:0]           wen_w;
   logic [N_SEG-1:0][SZ_W-1:0] sz_w;
   logic [N_SEG-1:0][HB-1:0]   lb_w;
   logic [N_SEG-1:0][PB-1:0]   pb_w;

   seg_desc_table #(
      .N     (N_SEG),
      .IDX_W (IDX_W),
      .HB    (HB),
      .PB    (PB),
      .SZ_W  (SZ_W),
      .DW    (DW)
   ) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (commit_w),
      .idx_i   (cmd_idx_w),
      .fld_i   (cmd_fld_w),
      .wdata_i (cmd_wdata_w),
      .rdata_o (tbl_rdata_w),
      .vld_o   (vld_w),
      .wen_o   (wen_w),
      .sz_o    (sz_w),
      .lbase_o (lb_w),
      .pbase_o (pb_w)
   );

   // Associative lookup
   logic [HB-1:0]    la_hi_w;
   logic             hit_w;
   logic [IDX_W-1:0] sel_w;
   logic [HB-1:0]    mask_w;

   assign la_hi_w = la_i[LA_W-1:MIN_SHIFT];

   seg_cam_match #(
      .N     (N_SEG),
      .HB    (HB),
      .SZ_W  (SZ_W),
      .IDX_W (IDX_W)
   ) u_cam (
      .la_hi_i (la_hi_w),
      .vld_i   (vld_w),
      .sz_i    (sz_w),
      .lbase_i (lb_w),
      .hit_o   (hit_w),
      .sel_o   (sel_w),
      .mask_o  (mask_w)
   );

   // Relocation: base above the boundary, logical offset below it.
   logic [PB-1:0]   mext_w;
   logic [PB-1:0]   lhx_w;
   logic [PB-1:0]   pa_hi_w;
   logic [PA_W-1:0] pa_w;

   always_comb begin
      mext_w          = '1;
      mext_w[HB-1:0]  = mask_w;
      lhx_w           = '0;
      lhx_w[HB-1:0]   = la_hi_w;
      pa_hi_w         = (pb_w[sel_w] & mext_w) | (lhx_w & ~mext_w);
      pa_w            = {pa_hi_w, la_i[MIN_SHIFT-1:0]};
   end

   // Permission check and result registers
   logic accept_w;
   logic deny_w;
   logic stb_q;
   logic fault_q;
   logic [PA_W-1:0] pa_q;

   assign accept_w = as_i && !busy_w;
   assign deny_w   = !hit_w || (wr_i && !wen_w[sel_w]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_q   <= 1'b0;
         fault_q <= 1'b0;
         pa_q    <= '0;
      end else begin
         stb_q   <= accept_w && !deny_w;
         fault_q <= accept_w && deny_w;
         if (accept_w) begin
            pa_q <= pa_w;
         end
      end
   end

   // Shared output pins: register data during acknowledge, else the address.
   logic [PA_W-1:0] rd_ext_w;
   always_comb begin
      rd_ext_w         = '0;
      rd_ext_w[DW-1:0] = port_rdata_w;
   end

   assign pbus_o    = ack_w ? rd_ext_w : pa_q;
   assign pa_stb_o  = stb_q;
   assign fault_o   = fault_q;
   assign reg_ack_o = ack_w;

endmodule

// File: rtl/seg_xlate_chk.sv
`timescale 1ns/1ps
module seg_xlate_chk #(
   parameter int unsigned REG_WAIT = 8
) (
   input logic clk,
   input logic rst_n,
   input logic as_i,
   input logic cs_i,
   input logic pa_stb_o,
   input logic fault_o,
   input logic reg_ack_o
);

   // Independent tracker of the register transfer window.
   logic       chk_busy;
   logic [7:0] chk_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_busy <= 1'b0;
         chk_cnt  <= '0;
      end else if (chk_busy && !reg_ack_o) begin
         chk_cnt <= chk_cnt + 8'd1;
      end else if (cs_i) begin
         chk_busy <= 1'b1;
         chk_cnt  <= '0;
      end else begin
         chk_busy <= 1'b0;
      end
   end

   AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pa_stb_o && fault_o)); // R7

   AST_RESULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_stb_o || fault_o) |-> $past(as_i)); // R7

   AST_NO_XLATE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (pa_stb_o || fault_o) |-> !$past(chk_busy && !reg_ack_o)); // R9

   AST_ACK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      reg_ack_o |-> (chk_busy && (chk_cnt == 8'(REG_WAIT)))); // R8

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_ack_o |=> !reg_ack_o); // R8

endmodule

bind seg_xlate_unit seg_xlate_chk #(.REG_WAIT(REG_WAIT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .as_i      (as_i),
   .cs_i      (cs_i),
   .pa_stb_o  (pa_stb_o),
   .fault_o   (fault_o),
   .reg_ack_o (reg_ack_o)
);

// File: tb/tb_seg_xlate_unit.sv
`timescale 1ns/1ps
module tb_seg_xlate_unit;

   localparam int N  = 32;
   localparam int RW = 11;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        as_i, wr_i, cs_i, reg_wr_i;
   logic [23:0] la_i;
   logic [4:0]  reg_idx_i;
   logic [1:0]  reg_fld_i;
   logic [15:0] reg_wdata_i;
   logic [23:0] pbus_o;
   logic        pa_stb_o, fault_o, reg_ack_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   bit        m_vld [N];
   bit        m_wen [N];
   bit [3:0]  m_sz  [N];
   bit [15:0] m_lb  [N];
   bit [15:0] m_pb  [N];

   always #4 clk = ~clk;

   seg_xlate_unit #(.N_SEG(N), .LA_W(24), .PA_W(24), .MIN_SHIFT(8),
                    .SZ_W(4), .DW(16), .REG_WAIT(RW)) dut (
      .clk(clk), .rst_n(rst_n), .as_i(as_i), .wr_i(wr_i), .la_i(la_i),
      .cs_i(cs_i), .reg_wr_i(reg_wr_i), .reg_idx_i(reg_idx_i),
      .reg_fld_i(reg_fld_i), .reg_wdata_i(reg_wdata_i), .pbus_o(pbus_o),
      .pa_stb_o(pa_stb_o), .fault_o(fault_o), .reg_ack_o(reg_ack_o));

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Expected {fault, physical address} from the requirement rules.
   function automatic bit [24:0] exp_xl(input bit [23:0] la, input bit wr);
      bit [15:0] hi;
      bit [15:0] m;
      hi = la[23:8];
      for (int i = 0; i < N; i++) begin
         m = 16'hFFFF << m_sz[i];
         if (m_vld[i] && (((hi ^ m_lb[i]) & m) == 16'h0)) begin
            if (wr && !m_wen[i]) return {1'b1, 24'h0};
            return {1'b0, ((m_pb[i] & m) | (hi & ~m)), la[7:0]};
         end
      end
      return {1'b1, 24'h0};
   endfunction

   function automatic bit [15:0] exp_rd(input int idx, input int fld);
      case (fld)
         0: return m_lb[idx];
         1: return m_pb[idx];
         2: return {8'h0, m_sz[idx], 2'b00, m_wen[idx], m_vld[idx]};
         default: return 16'h0;
      endcase
   endfunction

   task automatic reg_op(input bit wr, input int idx, input int fld,
                         input bit [15:0] wd, output bit [15:0] rd);
      int seen;
      @(negedge clk);
      cs_i = 1; reg_wr_i = wr; reg_idx_i = idx[4:0]; reg_fld_i = fld[1:0]; reg_wdata_i = wd;
      @(negedge clk);
      cs_i = 0;
      seen = 0;
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         if (reg_ack_o) begin seen = k; break; end
      end
      check(seen == RW, "R8", "acknowledge latency", seen, RW);
      rd = pbus_o[15:0];
      if (wr) begin
         case (fld)
            0: m_lb[idx] = wd;
            1: m_pb[idx] = wd;
            2: begin m_vld[idx] = wd[0]; m_wen[idx] = wd[1]; m_sz[idx] = wd[7:4]; end
            default: ;
         endcase
      end
   endtask

   task automatic wr_reg(input int idx, input int fld, input bit [15:0] wd);
      bit [15:0] d;
      reg_op(1'b1, idx, fld, wd, d);
   endtask

   task automatic rd_chk(input int idx, input int fld, input string req);
      bit [15:0] d;
      reg_op(1'b0, idx, fld, 16'h0, d);
      check(d == exp_rd(idx, fld), req, "register read", d, exp_rd(idx, fld));
   endtask

   task automatic prog(input int idx, input bit [15:0] lb, input bit [15:0] pb,
                       input bit v, input bit we, input bit [3:0] sz);
      wr_reg(idx, 0, lb);
      wr_reg(idx, 1, pb);
      wr_reg(idx, 2, {8'h0, sz, 2'b00, we, v});
   endtask

   task automatic xl(input bit [23:0] la, input bit wr, input string req);
      bit [24:0] e;
      @(negedge clk);
      as_i = 1; la_i = la; wr_i = wr;
      @(negedge clk);
      as_i = 0; wr_i = 0;
      e = exp_xl(la, wr);
      check((fault_o == e[24]) && (pa_stb_o == !e[24]), req, "strobe/fault",
            {30'h0, fault_o, pa_stb_o}, {30'h0, e[24], !e[24]});
      if (!e[24]) check(pbus_o == e[23:0], req, "physical address", pbus_o, e[23:0]);
   endtask

   initial begin
      bit [15:0] d;
      bit [23:0] la;
      int seen;
      void'($urandom(32'd20240917));
      rst_n = 0; as_i = 0; wr_i = 0; la_i = '0; cs_i = 0; reg_wr_i = 0;
      reg_idx_i = '0; reg_fld_i = '0; reg_wdata_i = '0;
      for (int i = 0; i < N; i++) begin
         m_vld[i] = 0; m_wen[i] = 0; m_sz[i] = 0; m_lb[i] = 0; m_pb[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      check({pa_stb_o, fault_o, reg_ack_o} == 3'b000, "R1", "outputs after reset",
            {pa_stb_o, fault_o, reg_ack_o}, 0);
      check(pbus_o == 24'h0, "R1", "pbus after reset", pbus_o, 0);
      rd_chk(0, 2, "R1");
      rd_chk(31, 2, "R1");
      for (int i = 0; i < 4; i++) begin
         xl(24'($urandom), i[0], "R1");
         check(fault_o == 1'b1, "R1", "empty table faults", fault_o, 1);
      end

      // R10 / R2 / R3: one 4 KB read-only segment with untidy low bits
      prog(5, 16'h1203, 16'hAB37, 1'b1, 1'b0, 4'd4);
      rd_chk(5, 0, "R10");
      rd_chk(5, 1, "R10");
      rd_chk(5, 2, "R10");
      rd_chk(5, 3, "R10");
      xl(24'h120ABC, 1'b0, "R3");
      check(pbus_o == 24'hAB3ABC, "R3", "directed relocation", pbus_o, 24'hAB3ABC);
      xl(24'h120FFF, 1'b0, "R2");
      xl(24'h120000, 1'b0, "R2");
      xl(24'h121000, 1'b0, "R5");
      check(fault_o == 1'b1, "R5", "just above segment", fault_o, 1);
      xl(24'h11FFFF, 1'b0, "R5");
      check(fault_o == 1'b1, "R5", "just below segment", fault_o, 1);

      // R7: result lasts one cycle
      xl(24'h120123, 1'b0, "R7");
      @(negedge clk);
      check({pa_stb_o, fault_o} == 2'b00, "R7", "strobe is one cycle", {pa_stb_o, fault_o}, 0);

      // R4: write protection
      xl(24'h120ABC, 1'b1, "R4");
      check(fault_o == 1'b1, "R4", "write to read-only segment", fault_o, 1);
      prog(9, 16'h3400, 16'h0100, 1'b1, 1'b1, 4'd0);
      xl(24'h340055, 1'b1, "R4");
      check(pa_stb_o == 1'b1 && pbus_o == 24'h010055, "R4", "write to writable 256 B segment",
            pbus_o, 24'h010055);
      xl(24'h340155, 1'b0, "R2");

      // R2: largest size code compares only the top bit
      prog(20, 16'h8000, 16'h0000, 1'b1, 1'b1, 4'd15);
      xl(24'hF12345, 1'b0, "R2");
      check(pbus_o == 24'h712345, "R2", "half-space segment", pbus_o, 24'h712345);

      // R6: lower entry overrides a higher overlapping entry
      prog(2, 16'h1200, 16'h4400, 1'b1, 1'b1, 4'd8);
      xl(24'h120ABC, 1'b1, "R6");
      check(pa_stb_o == 1'b1 && pbus_o == 24'h440ABC, "R6", "lowest entry wins", pbus_o, 24'h440ABC);
      wr_reg(2, 2, 16'h0000);
      xl(24'h120ABC, 1'b1, "R6");
      check(fault_o == 1'b1, "R6", "fallback to entry 5 permission", fault_o, 1);

      // R9: bus access and second request during a pending transfer
      @(negedge clk);
      cs_i = 1; reg_wr_i = 0; reg_idx_i = 5'd5; reg_fld_i = 2'd1;
      @(negedge clk);
      cs_i = 0; as_i = 1; la_i = 24'h120ABC; wr_i = 0;
      @(negedge clk);
      as_i = 0;
      check({pa_stb_o, fault_o} == 2'b00, "R9", "access ignored while busy", {pa_stb_o, fault_o}, 0);
      cs_i = 1; reg_wr_i = 1; reg_idx_i = 5'd5; reg_fld_i = 2'd1; reg_wdata_i = 16'hFFFF;
      @(negedge clk);
      cs_i = 0;
      seen = 0;
      for (int k = 3; k <= 40; k++) begin
         @(negedge clk);
         if (reg_ack_o) begin seen = k; break; end
      end
      check(seen == RW, "R8", "latency with overlapping requests", seen, RW);
      check(pbus_o[15:0] == 16'hAB37, "R8", "read data on shared pins", pbus_o[15:0], 16'hAB37);
      @(negedge clk);
      check(reg_ack_o == 1'b0, "R8", "acknowledge is one cycle", reg_ack_o, 0);
      rd_chk(5, 1, "R9");

      // Random descriptor sets and accesses
      for (int r = 0; r < 4; r++) begin
         for (int e = 0; e < 6; e++) begin
            int idx;
            idx = int'($urandom_range(0, N - 1));
            prog(idx, 16'($urandom), 16'($urandom), ($urandom_range(0, 7) != 0),
                 1'($urandom), 4'($urandom));
            rd_chk(idx, int'($urandom_range(0, 3)), "R10");
         end
         for (int a = 0; a < 40; a++) begin
            int idx;
            bit [15:0] m;
            idx = int'($urandom_range(0, N - 1));
            m = 16'hFFFF << m_sz[idx];
            la = 24'($urandom);
            if (a[0]) la[23:8] = (m_lb[idx] & m) | (la[23:8] & ~m);
            xl(la, 1'($urandom), a[0] ? "R6" : "R2");
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule